// File: doc/BRIEF.md
# Asynchronous static RAM access controller

This block sits between synchronous on-chip logic and an external asynchronous 64K x 16 static RAM. On-chip logic issues one word at a time over a valid/ready handshake. Each request carries a read/write flag, a 16-bit word address, 16-bit write data and a two-bit byte enable. The controller turns each request into a memory cycle whose phases last a whole number of clock cycles. Those counts are derived at elaboration from nanosecond minimums and the clock period, each rounded up to at least one cycle. Read results return with a one-cycle valid strobe.

All memory-side controls are active low and registered. There are chip select, write strobe, output enable, and one byte control for each lane. The data bus is split into an output value, an output-driver enable and an input value. A write is the overlap of chip select and write strobe, and it ends when the write strobe rises. Write data is driven one cycle before the strobe falls and is released on the edge where the strobe rises. After an access the chip stays selected, so accesses in the same direction follow each other with no deselect. When the direction changes, the controller inserts one cycle with chip select high. This also keeps the write driver and the memory's read driver from overlapping.

With the default 5 ns clock the phase counts are as follows. A read holds its controls for 15 cycles. A write has 1 data-setup cycle, 11 strobe-low cycles and 2 recovery cycles.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, chip select, write strobe, output enable and both byte controls are high, the data driver is off, req_ready is 1 and rsp_valid is 0.
- R2: A read drives chip select low, write strobe high and output enable low on a stable address for N_RD+1 cycles. N_RD is the largest of the rounded-up address-access, read-cycle, output-enable-access and byte-access times (14 at defaults). The input bus is sampled on the last of those edges. rsp_valid is high for exactly one cycle, N_RD+1 edges after the accepting edge, or N_RD+2 edges when a direction-change gap was inserted.
- R3: Byte enable bit 0 selects the lower lane, bits [7:0], driven by the lower byte control. Bit 1 selects the upper lane, bits [15:8], driven by the upper byte control. On a read, a lane whose enable is 0 returns 0 in rsp_rdata.
- R4: A write stores only the lanes whose enable bit is 1. Every other lane of the addressed word keeps its old value, including all lanes when the enable is 00.
- R5: In a write, the write strobe is low for at least ceil(50/Tclk) cycles. The data is driven and stable for at least ceil(30/Tclk) cycles up to the end of the write. Each enabled byte control is low for at least ceil(60/Tclk) cycles up to the end of the write. At defaults these are 10, 6 and 12 cycles.
- R6: The write strobe is low only while chip select is low, and the address does not change while the write strobe is low.
- R7: The data driver is enabled only in the cycle just before the write strobe falls and while the strobe is low. It is never enabled while output enable is low or while chip select is high.
- R8: When an access is in the opposite direction to the previous access, chip select is high for at least one cycle before the new access begins.
- R9: When an access is in the same direction as the previous access, chip select stays low between the two accesses.
- R10: req_ready is 0 from the accepting edge until the access finishes. A request held valid while ready is 0 is accepted exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enable, bit 0 lower lane, bit 1 upper lane |
| rsp_valid | output | 1 | Read data strobe, one cycle |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Lower byte control, active low |
| mem_ub_n | output | 1 | Upper byte control, active low |
| mem_addr | output | 16 | Memory address |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_in | input | 16 | Data returned by the memory |

## Verification
The properties check the following on every cycle: the bus is never driven against output enable, the driver is off while the chip is deselected, and the driver leads the write strobe by a single cycle. They also check that the address holds under a write or read strobe, that ready stays low while an access runs, that the response is a one-cycle pulse, and that the deselect gap appears on each change of direction and only then. The bench's scenarios add what needs memory contents or elapsed time. A behavioural memory model gives data only after the access time. It measures the strobe, byte-control and data-setup durations at the end of each write and stores only the lanes that were enabled. Read-back then shows byte masking, disabled lanes returning zero, extreme addresses, the exact response latency with and without a gap, and that a held request is taken once.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

    localparam int ADDR_W    = 16;
    localparam int LANE_W    = 8;
    localparam int NUM_LANES = 2;
    localparam int DATA_W    = LANE_W * NUM_LANES;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_RD,
        ST_WSET,
        ST_WPUL,
        ST_WREC
    } seq_state_e;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic ub_n;
        logic lb_n;
        logic dq_oe;
    } pin_set_t;

    localparam pin_set_t PINS_OFF = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1,
                                      ub_n: 1'b1, lb_n: 1'b1, dq_oe: 1'b0};

    function automatic int ns_to_cycles(input int t_ns, input int period_ns);
        int c;
        c = (t_ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic pin_set_t pins_for(input seq_state_e st,
                                          input logic parked,
                                          input logic [NUM_LANES-1:0] be);
        pin_set_t p;
        p = PINS_OFF;
        case (st)
            ST_IDLE: p.ce_n = ~parked;
            ST_TURN: p.ce_n = 1'b1;
            ST_RD: begin
                p.ce_n = 1'b0;
                p.oe_n = 1'b0;
                p.lb_n = ~be[0];
                p.ub_n = ~be[1];
            end
            ST_WSET: begin
                p.ce_n  = 1'b0;
                p.lb_n  = ~be[0];
                p.ub_n  = ~be[1];
                p.dq_oe = 1'b1;
            end
            ST_WPUL: begin
                p.ce_n  = 1'b0;
                p.we_n  = 1'b0;
                p.lb_n  = ~be[0];
                p.ub_n  = ~be[1];
                p.dq_oe = 1'b1;
            end
            ST_WREC: p.ce_n = 1'b0;
            default: p = PINS_OFF;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] value,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= value - CNT_W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int N_RD  = 14,
    parameter int N_WP  = 11,
    parameter int N_REC = 2,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             tmr_done,
    output logic             req_ready,
    output logic             accept,
    output seq_state_e       state_d,
    output logic             parked_d,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_value,
    output logic             rd_capture
);
    seq_state_e state_q;
    logic       parked_q;
    logic       last_wr_q;

    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        accept     = req_valid && req_ready;
        state_d    = state_q;
        parked_d   = parked_q;
        tmr_load   = 1'b0;
        tmr_value  = CNT_W'(N_RD + 1);
        rd_capture = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (parked_q && (last_wr_q != req_write)) begin
                        state_d = ST_TURN;
                    end else if (req_write) begin
                        state_d = ST_WSET;
                    end else begin
                        state_d  = ST_RD;
                        tmr_load = 1'b1;
                    end
                end
            end
            ST_TURN: begin
                if (last_wr_q) begin
                    state_d = ST_WSET;
                end else begin
                    state_d  = ST_RD;
                    tmr_load = 1'b1;
                end
            end
            ST_RD: begin
                if (tmr_done) begin
                    state_d    = ST_IDLE;
                    parked_d   = 1'b1;
                    rd_capture = 1'b1;
                end
            end
            ST_WSET: begin
                state_d   = ST_WPUL;
                tmr_load  = 1'b1;
                tmr_value = CNT_W'(N_WP);
            end
            ST_WPUL: begin
                if (tmr_done) begin
                    state_d   = ST_WREC;
                    tmr_load  = 1'b1;
                    tmr_value = CNT_W'(N_REC);
                end
            end
            ST_WREC: begin
                if (tmr_done) begin
                    state_d  = ST_IDLE;
                    parked_d = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            parked_q  <= 1'b0;
            last_wr_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            parked_q <= parked_d;
            if (accept) begin
                last_wr_q <= req_write;
            end
        end
    end
endmodule

// File: rtl/sram_pin_drive.sv
`timescale 1ns/1ps
module sram_pin_drive
    import sram_ctrl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 accept,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic [NUM_LANES-1:0] req_be,
    input  seq_state_e           state_d,
    input  logic                 parked_d,
    output pin_set_t             pins_q,
    output logic [ADDR_W-1:0]    addr_q,
    output logic [DATA_W-1:0]    wdata_q,
    output logic [NUM_LANES-1:0] be_q
);
    logic [NUM_LANES-1:0] be_d;

    assign be_d = accept ? req_be : be_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pins_q  <= PINS_OFF;
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
        end else begin
            pins_q <= pins_for(state_d, parked_d, be_d);
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                be_q    <= req_be;
            end
        end
    end
endmodule

// File: rtl/sram_rd_capture.sv
`timescale 1ns/1ps
module sram_rd_capture
    import sram_ctrl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 capture,
    input  logic [NUM_LANES-1:0] lane_en,
    input  logic [DATA_W-1:0]    dq_in,
    output logic                 rsp_valid,
    output logic [DATA_W-1:0]    rsp_rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= capture;
        end
    end

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                rsp_rdata[g*LANE_W +: LANE_W] <= '0;
            end else if (capture) begin
                rsp_rdata[g*LANE_W +: LANE_W] <=
                    lane_en[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
            end
        end
    end
endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 5,
    parameter int T_RC_NS       = 70,
    parameter int T_AA_NS       = 70,
    parameter int T_OE_NS       = 50,
    parameter int T_BA_NS       = 40,
    parameter int T_WC_NS       = 70,
    parameter int T_WP_NS       = 50,
    parameter int T_DW_NS       = 30,
    parameter int T_BW_NS       = 60
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic [15:0] req_addr,
    input  logic [15:0] req_wdata,
    input  logic [1:0]  req_be,
    output logic        rsp_valid,
    output logic [15:0] rsp_rdata,
    output logic        mem_ce_n,
    output logic        mem_we_n,
    output logic        mem_oe_n,
    output logic        mem_lb_n,
    output logic        mem_ub_n,
    output logic [15:0] mem_addr,
    output logic [15:0] mem_dq_out,
    output logic        mem_dq_oe,
    input  logic [15:0] mem_dq_in
);
    localparam int N_RD = max_int(
        max_int(ns_to_cycles(T_AA_NS, CLK_PERIOD_NS), ns_to_cycles(T_RC_NS, CLK_PERIOD_NS)),
        max_int(ns_to_cycles(T_OE_NS, CLK_PERIOD_NS), ns_to_cycles(T_BA_NS, CLK_PERIOD_NS)));
    localparam int N_WP = max_int(ns_to_cycles(T_WP_NS, CLK_PERIOD_NS),
        max_int(ns_to_cycles(T_DW_NS, CLK_PERIOD_NS) - 1,
                ns_to_cycles(T_BW_NS, CLK_PERIOD_NS) - 1));
    localparam int N_REC = max_int(1, ns_to_cycles(T_WC_NS, CLK_PERIOD_NS) - 1 - N_WP);
    localparam int CNT_W = $clog2(max_int(N_RD + 1, max_int(N_WP, N_REC)) + 1);

    logic             accept;
    seq_state_e       state_d;
    logic             parked_d;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_value;
    logic             tmr_done;
    logic             rd_capture;
    pin_set_t         pins_q;
    logic [1:0]       be_q;

    sram_seq_fsm #(
        .N_RD (N_RD),
        .N_WP (N_WP),
        .N_REC(N_REC),
        .CNT_W(CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .tmr_done  (tmr_done),
        .req_ready (req_ready),
        .accept    (accept),
        .state_d   (state_d),
        .parked_d  (parked_d),
        .tmr_load  (tmr_load),
        .tmr_value (tmr_value),
        .rd_capture(rd_capture)
    );

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (tmr_load),
        .value(tmr_value),
        .done (tmr_done)
    );

    sram_pin_drive u_pins (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .req_be   (req_be),
        .state_d  (state_d),
        .parked_d (parked_d),
        .pins_q   (pins_q),
        .addr_q   (mem_addr),
        .wdata_q  (mem_dq_out),
        .be_q     (be_q)
    );

    sram_rd_capture u_rd (
        .clk      (clk),
        .rst      (rst),
        .capture  (rd_capture),
        .lane_en  (be_q),
        .dq_in    (mem_dq_in),
        .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata)
    );

    assign mem_ce_n  = pins_q.ce_n;
    assign mem_we_n  = pins_q.we_n;
    assign mem_oe_n  = pins_q.oe_n;
    assign mem_lb_n  = pins_q.lb_n;
    assign mem_ub_n  = pins_q.ub_n;
    assign mem_dq_oe = pins_q.dq_oe;
endmodule

// File: rtl/sram_async_ctrl_chk.sv
`timescale 1ns/1ps
module sram_async_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic        mem_ce_n,
    input logic        mem_we_n,
    input logic        mem_oe_n,
    input logic [15:0] mem_addr,
    input logic        mem_dq_oe
);
    logic oe_n_q;
    logic we_n_q;
    logic gap_q;
    logic have_prev_q;
    logic last_wr_q;
    logic start_rd;
    logic start_wr;

    assign start_rd = oe_n_q && !mem_oe_n;
    assign start_wr = we_n_q && !mem_we_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_n_q      <= 1'b1;
            we_n_q      <= 1'b1;
            gap_q       <= 1'b0;
            have_prev_q <= 1'b0;
            last_wr_q   <= 1'b0;
        end else begin
            oe_n_q <= mem_oe_n;
            we_n_q <= mem_we_n;
            if (start_rd || start_wr) begin
                gap_q       <= 1'b0;
                have_prev_q <= 1'b1;
                last_wr_q   <= start_wr;
            end else if (mem_ce_n) begin
                gap_q <= 1'b1;
            end
        end
    end

    AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (rst)
        !(mem_dq_oe && !mem_oe_n)); // R7
    AST_DQ_OFF_DESEL: assert property (@(posedge clk) disable iff (rst)
        mem_ce_n |-> !mem_dq_oe); // R7
    AST_DQ_LEAD_ONE: assert property (@(posedge clk) disable iff (rst)
        (mem_dq_oe && mem_we_n) |=> !mem_we_n); // R7
    AST_WE_UNDER_CE: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> !mem_ce_n); // R6
    AST_WR_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |=> (mem_we_n || $stable(mem_addr))); // R6
    AST_RD_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |=> (mem_oe_n || $stable(mem_addr))); // R2
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        (!mem_oe_n || !mem_we_n) |-> !req_ready); // R10
    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R2
    AST_TURN_GAP_RD: assert property (@(posedge clk) disable iff (rst)
        (start_rd && have_prev_q && last_wr_q) |-> gap_q); // R8
    AST_TURN_GAP_WR: assert property (@(posedge clk) disable iff (rst)
        (start_wr && have_prev_q && !last_wr_q) |-> gap_q); // R8
    AST_SAME_DIR_RD: assert property (@(posedge clk) disable iff (rst)
        (start_rd && have_prev_q && !last_wr_q) |-> !gap_q); // R9
    AST_SAME_DIR_WR: assert property (@(posedge clk) disable iff (rst)
        (start_wr && have_prev_q && last_wr_q) |-> !gap_q); // R9
endmodule

bind sram_async_ctrl sram_async_ctrl_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .mem_ce_n (mem_ce_n),
    .mem_we_n (mem_we_n),
    .mem_oe_n (mem_oe_n),
    .mem_addr (mem_addr),
    .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_async_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_async_ctrl_tb_top;

    function automatic int cyc_of(input int t_ns);
        return (t_ns + 4) / 5;
    endfunction

    localparam int ACC_C = cyc_of(70);
    localparam int WP_C  = cyc_of(50);
    localparam int DW_C  = cyc_of(30);
    localparam int BW_C  = cyc_of(60);
    localparam int LAT_C = ACC_C + 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n;
    logic [15:0] mem_addr, mem_dq_out;
    logic        mem_dq_oe;
    logic [15:0] mem_dq_in = 16'hEEEE;

    always #2.5 clk = ~clk;

    sram_async_ctrl dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_addr(mem_addr),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Scoreboard reference and expected-response queue
    logic [15:0] ref_mem [int];
    typedef struct { logic [15:0] data; int acc; int lat; } exp_t;
    exp_t exp_q[$];
    bit prev_valid = 0;
    bit prev_wr    = 0;

    function automatic logic [15:0] lane_mask(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    task automatic issue(input bit wr, input logic [15:0] a,
                         input logic [15:0] d, input logic [1:0] be);
        bit turn;
        exp_t e;
        logic [15:0] old;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        turn = prev_valid && (prev_wr != wr);
        prev_valid = 1; prev_wr = wr;
        chk(!req_ready, "R10", "ready after accept", {31'b0, req_ready}, 0);
        req_valid = 1'b0;
        old = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0000;
        if (wr) begin
            ref_mem[int'(a)] = (old & ~lane_mask(be)) | (d & lane_mask(be));
        end else begin
            e.data = old & lane_mask(be);
            e.acc  = cyc;
            e.lat  = turn ? LAT_C + 1 : LAT_C;
            exp_q.push_back(e);
        end
    endtask

    // Monitor: pops expected reads as responses appear
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R10", "response with none outstanding", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(rsp_rdata == e.data, "R3", "read data", rsp_rdata, e.data);
                chk((cyc - e.acc) == e.lat, "R2", "read latency", cyc - e.acc, e.lat);
            end
        end
    end

    // Behavioural memory model with timing measurement
    logic [15:0] mdl_mem [int];
    int  rd_cnt, wp_run, lb_run, ub_run, dq_run;
    int  s_lb, s_ub, s_dq;
    logic [15:0] dq_last, w_addr, w_data;
    bit  w_lb, w_ub, addr_moved;
    bit  prev_oe, prev_we, ce_seen, have_prev, prev_dir;

    always @(negedge clk) begin
        if (rst) begin
            rd_cnt = 0; wp_run = 0; lb_run = 0; ub_run = 0; dq_run = 0;
            addr_moved = 0; prev_oe = 1; prev_we = 1; ce_seen = 0;
            have_prev = 0; prev_dir = 0; mem_dq_in = 16'hEEEE; dq_last = '0;
        end else begin
            logic [15:0] w;
            bit act, srd, swr;
            // read side: valid data only after the access time
            if (!mem_ce_n && mem_we_n && !mem_oe_n) begin
                rd_cnt++;
                w = mdl_mem.exists(int'(mem_addr)) ? mdl_mem[int'(mem_addr)] : 16'h0000;
                mem_dq_in[7:0]  = (rd_cnt >= ACC_C && !mem_lb_n) ? w[7:0]  : 8'hEE;
                mem_dq_in[15:8] = (rd_cnt >= ACC_C && !mem_ub_n) ? w[15:8] : 8'hEE;
            end else begin
                rd_cnt = 0;
                mem_dq_in = 16'hEEEE;
            end
            // write side
            act = !mem_ce_n && !mem_we_n;
            lb_run = mem_lb_n ? 0 : lb_run + 1;
            ub_run = mem_ub_n ? 0 : ub_run + 1;
            dq_run = !mem_dq_oe ? 0 : ((dq_run > 0 && mem_dq_out == dq_last) ? dq_run + 1 : 1);
            dq_last = mem_dq_out;
            if (act) begin
                if (wp_run > 0 && mem_addr != w_addr) addr_moved = 1;
                wp_run++;
                w_addr = mem_addr; w_data = mem_dq_out;
                w_lb = !mem_lb_n; w_ub = !mem_ub_n;
                s_lb = lb_run; s_ub = ub_run; s_dq = dq_run;
            end else if (wp_run > 0) begin
                chk(wp_run >= WP_C, "R5", "write strobe cycles", wp_run, WP_C);
                chk(s_dq >= DW_C, "R5", "data setup cycles", s_dq, DW_C);
                if (w_lb) chk(s_lb >= BW_C, "R5", "lower byte ctl cycles", s_lb, BW_C);
                if (w_ub) chk(s_ub >= BW_C, "R5", "upper byte ctl cycles", s_ub, BW_C);
                chk(!addr_moved, "R6", "address moved under strobe", {31'b0, addr_moved}, 0);
                w = mdl_mem.exists(int'(w_addr)) ? mdl_mem[int'(w_addr)] : 16'h0000;
                if (w_lb) w[7:0]  = w_data[7:0];
                if (w_ub) w[15:8] = w_data[15:8];
                mdl_mem[int'(w_addr)] = w;
                wp_run = 0; addr_moved = 0;
            end
            // deselect-gap side
            if (mem_ce_n) ce_seen = 1;
            srd = !mem_oe_n && prev_oe;
            swr = !mem_we_n && prev_we;
            if (srd || swr) begin
                if (have_prev) begin
                    if (prev_dir != swr)
                        chk(ce_seen, "R8", "gap on direction change", {31'b0, ce_seen}, 1);
                    else
                        chk(!ce_seen, "R9", "no gap same direction", {31'b0, ce_seen}, 0);
                end
                have_prev = 1; prev_dir = swr; ce_seen = 0;
            end
            prev_oe = mem_oe_n; prev_we = mem_we_n;
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "R10", "watchdog expired", 1, 0);
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk({mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n} == 5'b11111,
            "R1", "controls idle", {mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}, 5'b11111);
        chk(!mem_dq_oe, "R1", "driver off", {31'b0, mem_dq_oe}, 0);
        chk(req_ready && !rsp_valid, "R1", "ready/valid", {req_ready, rsp_valid}, 2'b10);

        // full word write then read (direction change, R2 R8)
        issue(1, 16'h0010, 16'hA5C3, 2'b11);
        issue(0, 16'h0010, 16'h0000, 2'b11);

        // byte-lane writes, back-to-back same direction (R4 R9)
        issue(1, 16'h0020, 16'h1234, 2'b11);
        issue(1, 16'h0020, 16'h99AB, 2'b01);
        issue(1, 16'h0020, 16'hCD77, 2'b10);
        issue(1, 16'h0020, 16'hFFFF, 2'b00);
        issue(0, 16'h0020, 16'h0000, 2'b11);
        // disabled lanes read as zero (R3)
        issue(0, 16'h0020, 16'h0000, 2'b01);
        issue(0, 16'h0020, 16'h0000, 2'b10);
        issue(0, 16'h0020, 16'h0000, 2'b00);

        // address extremes (R4)
        issue(1, 16'h0000, 16'h0F0F, 2'b11);
        issue(1, 16'hFFFF, 16'hF00D, 2'b11);
        issue(0, 16'hFFFF, 16'h0000, 2'b11);
        issue(0, 16'h0000, 16'h0000, 2'b11);

        // idle gap between requests keeps selection, then mixed traffic
        repeat (5) @(negedge clk);
        issue(0, 16'h0010, 16'h0000, 2'b11);
        lfsr = 16'hACE1;
        for (int i = 0; i < 40; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            issue(lfsr[0], {12'h400, lfsr[7:4]}, lfsr ^ 16'h5A5A, lfsr[3:2]);
        end

        repeat (40) @(negedge clk);
        chk(exp_q.size() == 0, "R2", "responses outstanding", exp_q.size(), 0);
        finish_run();
    end
endmodule